// File: doc/BRIEF.md
# Sample Memory DMA Transfer Engine

This block moves one burst of bytes between a host-side DMA byte stream and a local sample memory. Before a burst, software loads a 16-bit paragraph pointer and a 4-bit low nibble. When a burst is launched, the engine forms the local byte address from these two values. On a 16-bit host channel it remaps that address and moves two bytes per counted unit. Ahead of each burst it also advances the pointer pair by the burst length.

An 8-bit control register sets the direction. Uploads take the host stream into local memory, and downloads take local memory out to the host. It also selects a sign-bit flip on upload, a raw-first-byte option, and an interrupt enable. A burst that is flagged as the terminal one clears the enable bit when it finishes. It can also latch a pending interrupt. Reading the control register reports and clears that pending flag. Writing the register with the enable bit set emits a one-cycle request to the host-side DMA controller.

Top module: `smp_dma_engine`

## Requirements
- R1: On an 8-bit channel (`wide_chan`=0) the first byte goes to address para*16 + nib (20-bit). Each later byte goes to the next address up. One byte moves per count.
- R2: On a 16-bit channel (`wide_chan`=1) the base address a becomes (a AND 0xC0000) + 2*(a AND 0x1FFF0). Each count moves two bytes to consecutive addresses.
- R3: An accepted launch of length N adds N>>4 to the paragraph pointer, modulo 2^16. It sets the nibble to (nib + N) AND 0xF, with no carry into the paragraph pointer.
- R4: With control bit 1 clear, the burst writes memory from the host stream (`h_in_*`). With bit 1 set, it reads memory onto the host stream (`h_out_*`). The address advances only on a completed handshake.
- R5: On upload with control bit 7 set, bit 7 of each byte is inverted. With control bit 6 also set, the first byte of each unit is written unmodified: every byte on an 8-bit channel, or the even-indexed byte on a 16-bit channel. Download data is never modified.
- R6: When a terminal burst (`burst_tc`=1 at launch) completes, control bit 0 is cleared. A non-terminal burst leaves it unchanged.
- R7: When a terminal burst completes with control bit 5 set, `irq` goes high and stays high until the control register is read.
- R8: `ctl_rdata` shows the stored control byte, with bit 6 forced when an interrupt is pending and bit 2 forced when `wide_chan`=1. A `ctl_rd` strobe clears stored bits 6 and 2 and the pending flag.
- R9: A control write with bit 0 set raises `dma_req` for exactly the following cycle. A write with bit 0 clear does not raise it.
- R10: `busy` is high from the cycle after a launch until the terminal cycle that follows the last byte. A launch while busy is ignored and changes neither the pointers nor the burst.
- R11: A zero-length launch moves no byte and completes in the cycle after it starts, still applying R6 and R7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ctl_wr | input | 1 | Control register write strobe |
| ctl_rd | input | 1 | Control register read strobe (clear side effects) |
| ctl_wdata | input | 8 | Control write data |
| ctl_rdata | output | 8 | Control read value |
| para_wr | input | 1 | Paragraph pointer write strobe |
| para_wdata | input | 16 | Paragraph pointer write data |
| nib_wr | input | 1 | Low nibble write strobe |
| nib_wdata | input | 4 | Low nibble write data |
| para_q | output | 16 | Current paragraph pointer |
| nib_q | output | 4 | Current low nibble |
| wide_chan | input | 1 | Host channel is 16-bit |
| burst_start | input | 1 | Launch a burst |
| burst_len | input | CNT_W | Burst length in units |
| burst_tc | input | 1 | Burst ends at terminal count |
| busy | output | 1 | Burst in progress |
| h_in_valid | input | 1 | Host-to-memory byte valid |
| h_in_ready | output | 1 | Engine accepts host byte |
| h_in_data | input | 8 | Host-to-memory byte |
| h_out_valid | output | 1 | Memory-to-host byte valid |
| h_out_ready | input | 1 | Host accepts byte |
| h_out_data | output | 8 | Memory-to-host byte |
| mem_we | output | 1 | Local memory write |
| mem_re | output | 1 | Local memory read |
| mem_addr | output | 20 | Local memory byte address |
| mem_wdata | output | 8 | Local memory write data |
| mem_rdata | input | 8 | Local memory read data (same cycle) |
| dma_req | output | 1 | One-cycle DMA request |
| irq | output | 1 | Pending DMA interrupt |

## Verification
Several properties are checked on every cycle. The address holds while no handshake completes and steps by one after each completed one. `busy` stays high while bytes remain, and a zero-length launch ends one cycle later. An interrupt can only rise out of a terminal completion. A read strobe drops the interrupt, and a terminal completion drops the enable bit. Other behaviour can only be shown through the bench's scenarios. This covers the exact address arithmetic, including the 16-bit remap with high address bits set, and the sign-flip and raw-first-byte patterns across all option combinations. It also covers pointer advance with nibble wrap, the read-back format of the control byte, and a launch ignored while busy.

// File: rtl/smp_dma_pkg.sv
`timescale 1ns/1ps
package smp_dma_pkg;
    localparam int ADDR_W = 20;
    localparam int PARA_W = 16;
    localparam int NIB_W  = 4;

    // Control byte layout; bit positions are fixed by the register's behaviour.
    typedef struct packed {
        logic       flip;        // 7: invert sign bit on upload
        logic       keep_first;  // 6: first byte of each unit raw (stored)
        logic       irq_en;      // 5: raise irq at terminal count
        logic [1:0] spare;       // 4:3
        logic       wide_seen;   // 2: stored copy, cleared on read
        logic       to_host;     // 1: memory -> host
        logic       enable;      // 0: enable / request
    } ctl_t;

    typedef enum logic {ST_IDLE, ST_RUN} mv_state_e;

    typedef struct packed {
        logic to_host;
        logic flip;
        logic keep_first;
        logic wide;
        logic tc;
    } burst_cfg_t;

    function automatic logic [ADDR_W-1:0] base_addr(input logic [PARA_W-1:0] para,
                                                    input logic [NIB_W-1:0]  nib);
        return {para, 4'h0} + {{(ADDR_W-NIB_W){1'b0}}, nib};
    endfunction

    function automatic logic [ADDR_W-1:0] wide_map(input logic [ADDR_W-1:0] a);
        return (a & 20'hC0000) + ((a & 20'h1FFF0) << 1);
    endfunction

    function automatic logic [7:0] fix_byte(input logic [7:0] d, input logic flip_on,
                                            input logic keep, input logic first);
        if (keep && first) return d;
        return flip_on ? (d ^ 8'h80) : d;
    endfunction
endpackage

// File: rtl/smp_dma_regs.sv
`timescale 1ns/1ps
module smp_dma_regs
    import smp_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              para_wr,
    input  logic [PARA_W-1:0] para_wdata,
    input  logic              nib_wr,
    input  logic [NIB_W-1:0]  nib_wdata,
    output logic [PARA_W-1:0] para_q,
    output logic [NIB_W-1:0]  nib_q,
    input  logic              wide_chan,
    input  logic              start_acc,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              term,
    input  logic              term_tc,
    output logic              cfg_flip,
    output logic              cfg_keep,
    output logic              cfg_to_host,
    output logic              irq,
    output logic              dma_req
);
    ctl_t ctl;
    logic pend;
    logic tc_hit;

    assign tc_hit = term && term_tc;

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl     <= '0;
            pend    <= 1'b0;
            para_q  <= '0;
            nib_q   <= '0;
            dma_req <= 1'b0;
        end else begin
            dma_req <= ctl_wr && ctl_wdata[0];
            if (start_acc) begin
                para_q <= para_q + PARA_W'(start_cnt >> 4);
                nib_q  <= nib_q + start_cnt[NIB_W-1:0];
            end else begin
                if (para_wr) para_q <= para_wdata;
                if (nib_wr)  nib_q  <= nib_wdata;
            end
            if (ctl_wr) begin
                ctl <= ctl_t'(ctl_wdata);
            end else begin
                if (ctl_rd) begin
                    ctl.keep_first <= 1'b0;
                    ctl.wide_seen  <= 1'b0;
                end
                if (tc_hit) ctl.enable <= 1'b0;
            end
            if (tc_hit && ctl.irq_en) pend <= 1'b1;
            else if (ctl_rd)          pend <= 1'b0;
        end
    end

    assign ctl_rdata   = ctl | {1'b0, pend, 3'b000, wide_chan, 2'b00};
    assign irq         = pend;
    assign cfg_flip    = ctl.flip;
    assign cfg_keep    = ctl.keep_first;
    assign cfg_to_host = ctl.to_host;

    // R7: the interrupt only rises out of a terminal completion
    a_r7_irq_from_tc: assert property (@(posedge clk) disable iff (rst)
        $rose(irq) |-> $past(term && term_tc));
    // R8: a read strobe with no coinciding terminal event drops the interrupt
    a_r8_read_clears: assert property (@(posedge clk) disable iff (rst)
        (ctl_rd && !(term && term_tc)) |=> !irq);
    // R6: terminal completion clears enable unless overwritten
    a_r6_enable_drop: assert property (@(posedge clk) disable iff (rst)
        (term && term_tc && !ctl_wr) |=> !ctl_rdata[0]);
endmodule

// File: rtl/smp_dma_mover.sv
`timescale 1ns/1ps
module smp_dma_mover
    import smp_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start,
    input  logic [CNT_W-1:0]  start_cnt,
    input  logic              start_tc,
    input  logic              wide_chan,
    input  logic              cfg_flip,
    input  logic              cfg_keep,
    input  logic              cfg_to_host,
    input  logic [PARA_W-1:0] para,
    input  logic [NIB_W-1:0]  nib,
    output logic              start_acc,
    output logic              busy,
    output logic              term,
    output logic              term_tc,
    input  logic              h_in_valid,
    output logic              h_in_ready,
    input  logic [7:0]        h_in_data,
    output logic              h_out_valid,
    input  logic              h_out_ready,
    output logic [7:0]        h_out_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata
);
    localparam int LEFT_W = CNT_W + 1;

    mv_state_e         state;
    burst_cfg_t        cfg;
    logic [ADDR_W-1:0] cur;
    logic [LEFT_W-1:0] left;
    logic              odd;
    logic              active;
    logic              beat;
    logic [ADDR_W-1:0] launch_addr;

    assign launch_addr = wide_chan ? wide_map(base_addr(para, nib)) : base_addr(para, nib);
    assign start_acc   = start && (state == ST_IDLE);
    assign busy        = (state == ST_RUN);
    assign active      = busy && (left != '0);
    assign term        = busy && (left == '0);
    assign term_tc     = cfg.tc;
    assign beat        = active && (cfg.to_host ? h_out_ready : h_in_valid);

    assign h_in_ready  = active && !cfg.to_host;
    assign h_out_valid = active && cfg.to_host;
    assign h_out_data  = mem_rdata;
    assign mem_we      = active && !cfg.to_host && h_in_valid;
    assign mem_re      = active && cfg.to_host;
    assign mem_addr    = cur;
    assign mem_wdata   = fix_byte(h_in_data, cfg.flip && !cfg.to_host, cfg.keep_first,
                                  !odd || !cfg.wide);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg   <= '0;
            cur   <= '0;
            left  <= '0;
            odd   <= 1'b0;
        end else begin
            case (state)
                ST_IDLE: if (start) begin
                    cfg   <= '{to_host: cfg_to_host, flip: cfg_flip, keep_first: cfg_keep,
                               wide: wide_chan, tc: start_tc};
                    cur   <= launch_addr;
                    left  <= wide_chan ? {start_cnt, 1'b0} : {1'b0, start_cnt};
                    odd   <= 1'b0;
                    state <= ST_RUN;
                end
                ST_RUN: begin
                    if (left == '0) begin
                        state <= ST_IDLE;
                    end else if (beat) begin
                        cur  <= cur + 1'b1;
                        left <= left - 1'b1;
                        odd  <= ~odd;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R4: address holds across cycles without a handshake
    a_r4_addr_hold: assert property (@(posedge clk) disable iff (rst)
        (busy && !beat) |=> $stable(mem_addr));
    // R1: address steps by one after each moved byte
    a_r1_addr_step: assert property (@(posedge clk) disable iff (rst)
        beat |=> (mem_addr == $past(mem_addr) + 20'd1));
    // R10: busy persists while bytes remain
    a_r10_busy_hold: assert property (@(posedge clk) disable iff (rst)
        active |=> busy);
    // R11: zero-length launch finishes one cycle after it starts
    a_r11_zero_len: assert property (@(posedge clk) disable iff (rst)
        (start_acc && start_cnt == '0) |=> ##1 !busy);
endmodule

// File: rtl/smp_dma_engine.sv
`timescale 1ns/1ps
module smp_dma_engine
    import smp_dma_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              ctl_wr,
    input  logic              ctl_rd,
    input  logic [7:0]        ctl_wdata,
    output logic [7:0]        ctl_rdata,
    input  logic              para_wr,
    input  logic [15:0]       para_wdata,
    input  logic              nib_wr,
    input  logic [3:0]        nib_wdata,
    output logic [15:0]       para_q,
    output logic [3:0]        nib_q,
    input  logic              wide_chan,
    input  logic              burst_start,
    input  logic [CNT_W-1:0]  burst_len,
    input  logic              burst_tc,
    output logic              busy,
    input  logic              h_in_valid,
    output logic              h_in_ready,
    input  logic [7:0]        h_in_data,
    output logic              h_out_valid,
    input  logic              h_out_ready,
    output logic [7:0]        h_out_data,
    output logic              mem_we,
    output logic              mem_re,
    output logic [19:0]       mem_addr,
    output logic [7:0]        mem_wdata,
    input  logic [7:0]        mem_rdata,
    output logic              dma_req,
    output logic              irq
);
    logic start_acc, term, term_tc;
    logic cfg_flip, cfg_keep, cfg_to_host;

    smp_dma_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(clk), .rst(rst),
        .ctl_wr(ctl_wr), .ctl_rd(ctl_rd), .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata),
        .para_wr(para_wr), .para_wdata(para_wdata), .nib_wr(nib_wr), .nib_wdata(nib_wdata),
        .para_q(para_q), .nib_q(nib_q), .wide_chan(wide_chan),
        .start_acc(start_acc), .start_cnt(burst_len), .term(term), .term_tc(term_tc),
        .cfg_flip(cfg_flip), .cfg_keep(cfg_keep), .cfg_to_host(cfg_to_host),
        .irq(irq), .dma_req(dma_req)
    );

    smp_dma_mover #(.CNT_W(CNT_W)) u_mover (
        .clk(clk), .rst(rst),
        .start(burst_start), .start_cnt(burst_len), .start_tc(burst_tc),
        .wide_chan(wide_chan), .cfg_flip(cfg_flip), .cfg_keep(cfg_keep),
        .cfg_to_host(cfg_to_host), .para(para_q), .nib(nib_q),
        .start_acc(start_acc), .busy(busy), .term(term), .term_tc(term_tc),
        .h_in_valid(h_in_valid), .h_in_ready(h_in_ready), .h_in_data(h_in_data),
        .h_out_valid(h_out_valid), .h_out_ready(h_out_ready), .h_out_data(h_out_data),
        .mem_we(mem_we), .mem_re(mem_re), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata)
    );
endmodule

// File: tb/smp_dma_engine_tb.sv
`timescale 1ns/1ps
module smp_dma_engine_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ctl_wr = 0, ctl_rd = 0;
    logic [7:0]  ctl_wdata = 0;
    logic [7:0]  ctl_rdata;
    logic        para_wr = 0, nib_wr = 0;
    logic [15:0] para_wdata = 0;
    logic [3:0]  nib_wdata = 0;
    logic [15:0] para_q;
    logic [3:0]  nib_q;
    logic        wide_chan = 0;
    logic        burst_start = 0, burst_tc = 0;
    logic [15:0] burst_len = 0;
    logic        busy;
    logic        h_in_valid = 0, h_in_ready;
    logic [7:0]  h_in_data = 0;
    logic        h_out_valid, h_out_ready = 0;
    logic [7:0]  h_out_data;
    logic        mem_we, mem_re;
    logic [19:0] mem_addr;
    logic [7:0]  mem_wdata, mem_rdata;
    logic        dma_req, irq;

    logic [7:0]  bmem [0:4095];
    int          n_chk = 0, n_fail = 0;
    logic [7:0]  bctl = 0;
    logic        bpend = 0;
    logic [15:0] bpara = 0;
    logic [3:0]  bnib = 0;
    logic        exp_tc = 0;
    logic [19:0] a0 = 0;

    always #5 clk = ~clk;

    smp_dma_engine u_dut (.*);

    assign mem_rdata = bmem[mem_addr[11:0]];
    always @(posedge clk) if (mem_we) bmem[mem_addr[11:0]] <= mem_wdata;

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [19:0] exp_base(input logic [15:0] p, input logic [3:0] n,
                                             input logic w);
        logic [19:0] a;
        a = 20'(p * 16 + n);
        if (w) a = 20'((a & 20'hC0000) + 2 * (a & 20'h1FFF0));
        return a;
    endfunction

    task automatic wr_ctl(input logic [7:0] v);
        @(negedge clk); ctl_wr = 1; ctl_wdata = v;
        @(negedge clk); ctl_wr = 0; bctl = v;
        chk("R9 dma_req after write", dma_req, v[0]);
        @(negedge clk);
        chk("R9 dma_req single cycle", dma_req, 0);
    endtask

    task automatic set_addr(input logic [15:0] p, input logic [3:0] n);
        @(negedge clk); para_wr = 1; para_wdata = p; nib_wr = 1; nib_wdata = n;
        @(negedge clk); para_wr = 0; nib_wr = 0; bpara = p; bnib = n;
    endtask

    task automatic kick(input int cnt, input logic tc);
        a0 = exp_base(bpara, bnib, wide_chan);
        @(negedge clk); burst_start = 1; burst_len = 16'(cnt); burst_tc = tc;
        @(negedge clk); burst_start = 0;
        bpara = 16'(bpara + (cnt >> 4));
        bnib  = 4'(bnib + cnt);
        exp_tc = tc;
    endtask

    task automatic move_bytes(input int n, input logic up, input logic gap);
        for (int k = 0; k < n; k++) begin
            logic [7:0] d, e;
            logic first;
            if (gap && k == 1) begin
                h_in_valid = 0; h_out_ready = 0;
                #1 chk("R4 no write without valid", {mem_we, mem_addr}, {1'b0, 20'(a0 + k)});
                @(negedge clk);
            end
            if (up) begin
                d = 8'(k * 37 + 8'h5A);
                h_in_valid = 1; h_in_data = d;
                first = !wide_chan || (k % 2 == 0);
                e = (bctl[6] && first) ? d : (bctl[7] ? (d ^ 8'h80) : d);
                #1;
                chk("R1 R2 upload address", mem_addr, 20'(a0 + k));
                chk("R4 upload write strobe", {mem_we, h_in_ready}, 2'b11);
                chk("R5 upload data", mem_wdata, e);
            end else begin
                h_out_ready = 1;
                #1;
                chk("R1 R2 download address", mem_addr, 20'(a0 + k));
                chk("R4 download strobes", {h_out_valid, mem_re, mem_we}, 3'b110);
                chk("R5 download data unmodified", h_out_data, bmem[12'(a0 + k)]);
            end
            @(negedge clk);
        end
        h_in_valid = 0; h_out_ready = 0;
    endtask

    task automatic finish_chk();
        chk("R10 busy in terminal cycle", busy, 1);
        @(negedge clk);
        chk("R10 idle after terminal", busy, 0);
        if (exp_tc) begin
            if (bctl[5]) bpend = 1;
            bctl[0] = 0;
        end
        chk("R6 R8 control readback", ctl_rdata, bctl | {1'b0, bpend, 3'b0, wide_chan, 2'b0});
        chk("R7 irq level", irq, bpend);
        chk("R3 paragraph pointer", para_q, bpara);
        chk("R3 nibble", nib_q, bnib);
    endtask

    task automatic read_ctl();
        chk("R8 read value", ctl_rdata, bctl | {1'b0, bpend, 3'b0, wide_chan, 2'b0});
        @(negedge clk); ctl_rd = 1;
        @(negedge clk); ctl_rd = 0;
        bctl = bctl & 8'hBB; bpend = 0;
        chk("R8 read clears", ctl_rdata, bctl | {5'b0, wide_chan, 2'b0});
        chk("R8 irq dropped", irq, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4096; i++) bmem[i] = 8'(i * 13 + 5);
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        chk("R8 reset control", ctl_rdata, 0);
        chk("R7 reset irq", irq, 0);
        chk("R10 reset busy", busy, 0);
        chk("R3 reset pointers", {para_q, nib_q}, 0);
        chk("R9 reset request", dma_req, 0);

        // Upload sweep over channel width and sign options
        for (int w = 0; w < 2; w++) begin
            for (int m = 0; m < 4; m++) begin
                wide_chan = w[0];
                wr_ctl({m[0], m[1], 1'b1, 4'b0000, 1'b1});
                set_addr(16'(16'h0012 + m * 16'h0031 + w * 16'h0007), 4'(m * 5 + w * 3));
                kick(3 + m, 1);
                move_bytes((3 + m) * (w + 1), 1, m == 2);
                finish_chk();
                read_ctl();
            end
        end

        // Wide remap with high address bits set
        wide_chan = 1;
        wr_ctl(8'h01);
        set_addr(16'hC345, 4'h9);
        kick(2, 0);
        move_bytes(4, 1, 0);
        finish_chk();

        // Downloads: sign flip must not apply
        for (int w = 0; w < 2; w++) begin
            wide_chan = w[0];
            wr_ctl(8'hA3);
            set_addr(16'h0040, 4'hB);
            kick(4, 1);
            move_bytes(4 * (w + 1), 0, w == 1);
            finish_chk();
            read_ctl();
        end

        // Long burst: paragraph step, nibble wrap, non-terminal keeps enable
        wide_chan = 0;
        wr_ctl(8'h21);
        set_addr(16'hFFFF, 4'hE);
        kick(35, 0);
        move_bytes(35, 1, 0);
        finish_chk();
        chk("R6 enable kept on non-terminal", ctl_rdata[0], 1);
        chk("R7 no irq on non-terminal", irq, 0);

        // Zero-length terminal burst
        wr_ctl(8'h21);
        kick(0, 1);
        h_in_valid = 1;
        #1 chk("R11 no byte moved", {mem_we, h_in_ready}, 2'b00);
        h_in_valid = 0;
        finish_chk();
        chk("R11 irq after zero-length", irq, 1);
        read_ctl();

        // Launch while busy is ignored
        wr_ctl(8'h00);
        set_addr(16'h0100, 4'h3);
        kick(2, 0);
        @(negedge clk); burst_start = 1; burst_len = 16'd9;
        @(negedge clk); burst_start = 0;
        chk("R10 busy through ignored launch", busy, 1);
        move_bytes(2, 1, 0);
        finish_chk();

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule